// File: doc/BRIEF.md
# Half-Width Multiply and Divide Unit

This block is an integer multiply/divide execution unit for a microcoded datapath. Each operation takes two source operands, a destination value, a size selector (1, 2, 4 or 8 bytes) and an opcode. The unit returns the new destination after a start/done handshake. Before any arithmetic, both sources are cut down to the selected width. The result is then written back over the destination according to the size.

Three multiply flavours share one set of four half-width partial-product multipliers. The first is a product of the operands' lower halves. The second is the low half of the full-width product. The third is the high half of that product. Three divide flavours share one restoring shift-subtract divider that produces one quotient bit per cycle. One packs a half-width quotient and a half-width remainder into a single result. The other two return only the full-width quotient or only the full-width remainder. A zero divisor does not trap. It raises an error flag and leaves the destination untouched.

Top module: `muldiv_unit`

## Requirements
- R1: While reset is low, and afterwards until the first completion, `busy`, `done`, `divErr` and `result` are all zero.
- R2: `sizeSel` codes 0, 1, 2 and 3 select widths of 8, 16, 32 and 64 bits. Both sources are masked to the selected width before use, so higher bits have no effect. A divisor that is zero within the width counts as zero.
- R3: Opcode 0 multiplies the lower halves of the two masked operands. The half is width/2 bits.
- R4: Opcode 1 returns the low `width` bits of the product of the masked operands.
- R5: Opcode 2 returns the high `width` bits of the 2×`width`-bit product of the masked operands.
- R6: Opcode 3 divides. The quotient, masked to width/2 bits, goes in the lower half. The remainder, masked to width/2 bits, goes in bits [width-1 : width/2].
- R7: Opcode 4 returns the full-width quotient. Opcode 5 returns the full-width remainder.
- R8: Write-back merge. For sizes 1 and 2 bytes, destination bits above the width are kept. For size 4 bytes, bits 63..32 become zero. For size 8 bytes, the whole result is written.
- R9: For opcodes 3 to 5 with a zero divisor, `divErr` is 1 and `result` equals `destIn` unchanged. Every other completion clears `divErr`.
- R10: Suppose `start` is sampled in cycle c. Then `done` is high in cycle c+2 for multiply, reserved and zero-divisor operations. For a divide with a nonzero divisor, `done` is high in cycle c+2+width.
- R11: `done` is a single-cycle pulse. `busy` is high from the cycle after an accepted start until `done`. A `start` while busy is ignored and is not queued.
- R12: Opcodes 6 and 7 return `destIn` unchanged, with `divErr` = 0.
- R13: `result` and `divErr` hold their values between completions, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, accepted when not busy |
| opSel | input | 3 | Operation code |
| sizeSel | input | 2 | Operand size code |
| srcA | input | 64 | First source / dividend |
| srcB | input | 64 | Second source / divisor |
| destIn | input | 64 | Current destination value for the merge |
| busy | output | 1 | Operation in flight |
| done | output | 1 | One-cycle completion pulse |
| divErr | output | 1 | Zero-divisor flag of the last completion |
| result | output | 64 | Merged destination of the last completion |

## Verification
The hardest case to reach from the ports is a new request that arrives in the middle of a long divide. The divider must keep its partial remainder and must not latch the new operands. The stimulus starts a 64-bit divide and pulses `start` with a different multiply while the unit is busy. It then checks that only the divide's result appears and that no second completion follows. A second hard case is a divisor that is nonzero in its upper bits but zero within the selected width. A dedicated vector drives exactly that divisor, alongside a vector table and a sweep of every opcode and size against an independent wide-arithmetic model.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

  typedef enum logic [2:0] {
    OP_MUL_HALF = 3'd0,
    OP_MUL_LO   = 3'd1,
    OP_MUL_HI   = 3'd2,
    OP_DIV_PACK = 3'd3,
    OP_DIV_QUO  = 3'd4,
    OP_DIV_REM  = 3'd5,
    OP_RSV6     = 3'd6,
    OP_RSV7     = 3'd7
  } mdOp_e;

  // Control-to-datapath strobes
  typedef struct packed {
    logic load;     // capture request operands, seed divider
    logic step;     // one restoring divide iteration
    logic finish;   // write result register
    logic flagErr;  // completion is a zero-divisor error
  } mdStrobe_t;

  function automatic logic isDivOp(input logic [2:0] op);
    return (op == OP_DIV_PACK) || (op == OP_DIV_QUO) || (op == OP_DIV_REM);
  endfunction

  function automatic logic isKnownOp(input logic [2:0] op);
    return op <= OP_DIV_REM;
  endfunction

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
  import mdu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int CNTW = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic            reqIsDiv,
  input  logic            reqZero,
  input  logic [CNTW-1:0] reqWidth,
  output mdStrobe_t       strb,
  output logic            busy,
  output logic            done
);

  typedef enum logic [1:0] {S_IDLE, S_DIV, S_FIN} mdState_e;

  mdState_e        state, stateNext;
  logic [CNTW-1:0] bitCnt;
  logic            errPend;

  always_comb begin
    strb      = '0;
    stateNext = state;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strb.load = 1'b1;
          stateNext = (reqIsDiv && !reqZero) ? S_DIV : S_FIN;
        end
      end
      S_DIV: begin
        strb.step = 1'b1;
        if (bitCnt == CNTW'(1)) stateNext = S_FIN;
      end
      S_FIN: begin
        strb.finish  = 1'b1;
        strb.flagErr = errPend;
        stateNext    = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      bitCnt  <= '0;
      errPend <= 1'b0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == S_FIN);
      if (strb.load) begin
        bitCnt  <= reqWidth;
        errPend <= reqIsDiv && reqZero;
      end else if (strb.step) begin
        bitCnt <= bitCnt - CNTW'(1);
      end
    end
  end

  assign busy = (state != S_IDLE);

endmodule

// File: rtl/mdu_merge.sv
module mdu_merge #(
  parameter int XLEN       = 64,
  parameter int ZEXT_BYTES = 4,
  localparam int NBYTES    = XLEN / 8,
  localparam int CW        = $clog2(NBYTES + 1)
) (
  input  logic [1:0]      sizeSel,
  input  logic [XLEN-1:0] raw,
  input  logic [XLEN-1:0] dest,
  output logic [XLEN-1:0] merged
);

  logic [CW-1:0] nBytes;
  logic          zeroUpper;

  assign nBytes    = CW'(NBYTES >> (2'd3 - sizeSel));
  assign zeroUpper = (nBytes >= CW'(ZEXT_BYTES));

  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    assign merged[8*i +: 8] = (CW'(i) < nBytes) ? raw[8*i +: 8]
                            : (zeroUpper ? 8'h00 : dest[8*i +: 8]);
  end

endmodule

// File: rtl/mdu_datapath.sv
module mdu_datapath
  import mdu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2,
  localparam int CNTW = $clog2(XLEN + 1),
  localparam int XW2  = XLEN + 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  mdStrobe_t       strb,
  input  logic [2:0]      opSel,
  input  logic [1:0]      sizeSel,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  input  logic [XLEN-1:0] destIn,
  output logic            reqIsDiv,
  output logic            reqZero,
  output logic [CNTW-1:0] reqWidth,
  output logic [XLEN-1:0] result,
  output logic            divErr
);

  function automatic logic [CNTW-1:0] widthOf(input logic [1:0] sz);
    return CNTW'(XLEN >> (2'd3 - sz));
  endfunction

  function automatic logic [XLEN-1:0] maskOf(input logic [CNTW-1:0] w);
    return (w >= CNTW'(XLEN)) ? '1 : ((XLEN'(1) << w) - XLEN'(1));
  endfunction

  // Request decode (combinational, consumed at the accepting edge)
  logic [XLEN-1:0] reqMask, reqA, reqB;
  assign reqWidth = widthOf(sizeSel);
  assign reqMask  = maskOf(reqWidth);
  assign reqA     = srcA & reqMask;
  assign reqB     = srcB & reqMask;
  assign reqZero  = (reqB == '0);
  assign reqIsDiv = isDivOp(opSel);

  // Captured operation
  logic [2:0]      opR;
  logic [1:0]      sizeR;
  logic [XLEN-1:0] aR, bR, destR;
  logic [XLEN-1:0] quo, rem;

  logic [CNTW-1:0] wR, hR;
  logic [XLEN-1:0] wMask, hMask;
  assign wR    = widthOf(sizeR);
  assign hR    = wR >> 1;
  assign wMask = maskOf(wR);
  assign hMask = maskOf(hR);

  // Four half-width partial products
  logic [HALF-1:0] aHi, aLo, bHi, bLo;
  logic [XLEN-1:0] pLL, pLH, pHL, pHH;
  logic [XW2-1:0]  midSum, midCarry;
  logic [XLEN-1:0] loProd, hiProd;

  assign aHi = HALF'(aR >> hR);
  assign aLo = HALF'(aR & hMask);
  assign bHi = HALF'(bR >> hR);
  assign bLo = HALF'(bR & hMask);

  assign pLL = XLEN'(aLo) * XLEN'(bLo);
  assign pLH = XLEN'(aLo) * XLEN'(bHi);
  assign pHL = XLEN'(aHi) * XLEN'(bLo);
  assign pHH = XLEN'(aHi) * XLEN'(bHi);

  assign midSum   = XW2'(pLH) + XW2'(pHL);
  assign midCarry = midSum + XW2'(pLL >> hR);
  assign loProd   = (pLL + XLEN'(midSum << hR)) & wMask;
  assign hiProd   = (pHH + XLEN'(midCarry >> hR)) & wMask;

  // Restoring divide step
  logic [XLEN:0]   remShift;
  logic [XLEN+1:0] trial;
  logic            takeBit;
  assign remShift = {rem, quo[XLEN-1]};
  assign trial    = {1'b0, remShift} - {2'b00, bR};
  assign takeBit  = !trial[XLEN+1];

  // Raw result select
  logic [XLEN-1:0] raw, merged;
  logic            keepDest;

  always_comb begin
    unique case (opR)
      OP_MUL_HALF: raw = pLL & wMask;
      OP_MUL_LO:   raw = loProd;
      OP_MUL_HI:   raw = hiProd;
      OP_DIV_PACK: raw = (quo & hMask) | ((rem & hMask) << hR);
      OP_DIV_QUO:  raw = quo & wMask;
      OP_DIV_REM:  raw = rem & wMask;
      default:     raw = destR;
    endcase
  end

  assign keepDest = strb.flagErr || !isKnownOp(opR);

  mdu_merge #(.XLEN(XLEN)) u_merge (
    .sizeSel (sizeR),
    .raw     (raw),
    .dest    (destR),
    .merged  (merged)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opR    <= '0;
      sizeR  <= '0;
      aR     <= '0;
      bR     <= '0;
      destR  <= '0;
      quo    <= '0;
      rem    <= '0;
      result <= '0;
      divErr <= 1'b0;
    end else begin
      if (strb.load) begin
        opR   <= opSel;
        sizeR <= sizeSel;
        aR    <= reqA;
        bR    <= reqB;
        destR <= destIn;
        quo   <= reqA << (CNTW'(XLEN) - reqWidth);
        rem   <= '0;
      end else if (strb.step) begin
        quo <= {quo[XLEN-2:0], takeBit};
        rem <= takeBit ? XLEN'(trial) : XLEN'(remShift);
      end
      if (strb.finish) begin
        result <= keepDest ? destR : merged;
        divErr <= strb.flagErr;
      end
    end
  end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
  import mdu_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int CNTW = $clog2(XLEN + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [2:0]      opSel,
  input  logic [1:0]      sizeSel,
  input  logic [XLEN-1:0] srcA,
  input  logic [XLEN-1:0] srcB,
  input  logic [XLEN-1:0] destIn,
  output logic            busy,
  output logic            done,
  output logic            divErr,
  output logic [XLEN-1:0] result
);

  mdStrobe_t       strb;
  logic            reqIsDiv, reqZero;
  logic [CNTW-1:0] reqWidth;

  mdu_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .reqIsDiv (reqIsDiv),
    .reqZero  (reqZero),
    .reqWidth (reqWidth),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  mdu_datapath #(.XLEN(XLEN)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .opSel    (opSel),
    .sizeSel  (sizeSel),
    .srcA     (srcA),
    .srcB     (srcB),
    .destIn   (destIn),
    .reqIsDiv (reqIsDiv),
    .reqZero  (reqZero),
    .reqWidth (reqWidth),
    .result   (result),
    .divErr   (divErr)
  );

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic [2:0]      opSel,
  input logic            busy,
  input logic            done,
  input logic            divErr,
  input logic [XLEN-1:0] result
);

  logic [2:0] lastOp;
  always_ff @(posedge clk) begin
    if (!rstN) lastOp <= 3'd0;
    else if (start && !busy) lastOp <= opSel;
  end

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R11

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R11

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy); // R11

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(result)); // R13

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(divErr)); // R13

  AST_ERR_DIV_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (done && divErr) |-> (lastOp inside {3'd3, 3'd4, 3'd5})); // R9

  always_ff @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!done || !busy); // R1
    end
  end

endmodule

bind muldiv_unit muldiv_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .start  (start),
  .opSel  (opSel),
  .busy   (busy),
  .done   (done),
  .divErr (divErr),
  .result (result)
);

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;

  logic        clk = 1'b0;
  logic        rstN, start, busy, done, divErr;
  logic [2:0]  opSel;
  logic [1:0]  sizeSel;
  logic [63:0] srcA, srcB, destIn, result;
  int          errors = 0;
  int          checks = 0;

  always #5 clk = ~clk;

  muldiv_unit u_dut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel), .sizeSel(sizeSel),
    .srcA(srcA), .srcB(srcB), .destIn(destIn),
    .busy(busy), .done(done), .divErr(divErr), .result(result)
  );

  localparam logic [63:0] DST = 64'hAAAA_AAAA_AAAA_AAAA;
  localparam int NV = 16;
  localparam logic [2:0]  V_OP [NV] = '{0,1,2,3,4,5,2,1,0,4,5,1,4,6,3,0};
  localparam logic [1:0]  V_SZ [NV] = '{0,1,1,0,2,2,3,3,3,3,3,0,0,2,3,1};
  localparam logic [63:0] V_A  [NV] = '{64'h37, 64'h1234, 64'h1234, 64'h64,
    64'hFFFF_FFFF, 64'hFFFF_FFFF, '1, '1, '1, 64'h8000_0000_0000_0000,
    64'h8000_0000_0000_0000, 64'h1FF, 64'h55, 64'h1, 64'h0000_0001_0000_0007, 64'hFF12};
  localparam logic [63:0] V_B  [NV] = '{64'h2B, 64'h0100, 64'h0100, 64'h07,
    64'h10, 64'h10, '1, '1, '1, 64'h3, 64'h3, 64'h102, 64'h100, 64'h1, 64'h2, 64'hFF03};
  localparam logic [63:0] V_EXP [NV] = '{64'hAAAA_AAAA_AAAA_AA4D,
    64'hAAAA_AAAA_AAAA_3400, 64'hAAAA_AAAA_AAAA_0012, 64'hAAAA_AAAA_AAAA_AA2E,
    64'h0000_0000_0FFF_FFFF, 64'h0000_0000_0000_000F, 64'hFFFF_FFFF_FFFF_FFFE,
    64'h0000_0000_0000_0001, 64'hFFFF_FFFE_0000_0001, 64'h2AAA_AAAA_AAAA_AAAA,
    64'h0000_0000_0000_0002, 64'hAAAA_AAAA_AAAA_AAFE, DST, DST,
    64'h0000_0001_8000_0003, 64'hAAAA_AAAA_AAAA_0036};
  localparam logic V_ERR [NV] = '{0,0,0,0,0,0,0,0,0,0,0,0,1,0,0,0};
  string vReq [NV] = '{"R3","R4","R5","R6","R7_R8","R7","R5","R4","R3","R7","R7",
                       "R2","R9","R12","R6","R8"};

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void refModel(input logic [2:0] op, input logic [1:0] sz,
      input logic [63:0] a, input logic [63:0] b, input logic [63:0] d,
      output logic [63:0] r, output logic e, output int lat);
    int w = 8 << sz;
    int h = w / 2;
    logic [63:0] m  = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
    logic [63:0] hm = (64'd1 << h) - 64'd1;
    logic [63:0] am = a & m;
    logic [63:0] bm = b & m;
    logic [127:0] p = {64'd0, am} * {64'd0, bm};
    logic [127:0] ph = p >> w;
    logic [63:0] raw = d;
    e = 1'b0;
    lat = 2;
    case (op)
      3'd0: raw = (am & hm) * (bm & hm);
      3'd1: raw = p[63:0] & m;
      3'd2: raw = ph[63:0] & m;
      3'd3, 3'd4, 3'd5: begin
        if (bm == 0) e = 1'b1;
        else begin
          lat = w + 2;
          if (op == 3'd3) raw = ((am / bm) & hm) | (((am % bm) & hm) << h);
          else if (op == 3'd4) raw = am / bm;
          else raw = am % bm;
        end
      end
      default: raw = d;
    endcase
    if (e || op > 3'd5) r = d;
    else if (w >= 32) r = raw & m;
    else r = (d & ~m) | (raw & m);
  endfunction

  task automatic runOp(input logic [2:0] op, input logic [1:0] sz, input logic [63:0] a,
      input logic [63:0] b, input logic [63:0] d,
      output logic [63:0] r, output logic e, output int lat);
    opSel = op; sizeSel = sz; srcA = a; srcB = b; destIn = d; start = 1'b1;
    lat = 0;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    r = result;
    e = divErr;
  endtask

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'd0: return "R3";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4, 3'd5: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin : main
    logic [63:0] r, er, x, a, b;
    logic e, ee;
    int lat, elat, nDone;
    rstN = 1'b0; start = 1'b0; opSel = 3'd1; sizeSel = 2'd3;
    srcA = '1; srcB = '1; destIn = '1;
    repeat (3) @(negedge clk);
    // R1: quiet during reset even with start high inputs pending
    check("R1 busy", 64'(busy), 64'd0);
    check("R1 done", 64'(done), 64'd0);
    check("R1 divErr", 64'(divErr), 64'd0);
    check("R1 result", result, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 result after release", result, 64'd0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      runOp(V_OP[i], V_SZ[i], V_A[i], V_B[i], DST, r, e, lat);
      check(vReq[i], r, V_EXP[i]);
      check({vReq[i], " divErr R9"}, 64'(e), 64'(V_ERR[i]));
    end

    // Sweep of all opcodes and sizes against the model (R2, R8, R10)
    x = 64'h9E37_79B9_7F4A_7C15;
    for (int it = 0; it < 5; it++) begin
      for (int op = 0; op < 8; op++) begin
        for (int sz = 0; sz < 4; sz++) begin
          x ^= x << 13; x ^= x >> 7; x ^= x << 17; a = x;
          x ^= x << 13; x ^= x >> 7; x ^= x << 17;
          b = (it == 0) ? (x >> (x[5:0])) : x;
          refModel(3'(op), 2'(sz), a, b, ~a, er, ee, elat);
          runOp(3'(op), 2'(sz), a, b, ~a, r, e, lat);
          check({reqOf(3'(op)), " R2 R8 sweep"}, r, er);
          check("R9 sweep divErr", 64'(e), 64'(ee));
          check("R10 latency", 64'(lat), 64'(elat));
        end
      end
    end

    // R11: done is one cycle wide
    runOp(3'd1, 2'd3, 64'd5, 64'd6, DST, r, e, lat);
    @(negedge clk);
    check("R11 done pulse width", 64'(done), 64'd0);

    // R11: start while busy is ignored and not queued
    opSel = 3'd4; sizeSel = 2'd3; srcA = 64'd100; srcB = 64'd7; destIn = DST; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    check("R11 busy mid divide", 64'(busy), 64'd1);
    opSel = 3'd1; srcA = 64'd3; srcB = 64'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check("R11 first op result kept", result, 64'd14);
    nDone = 0;
    repeat (6) begin
      @(negedge clk);
      if (done) nDone++;
    end
    check("R11 no queued completion", 64'(nDone), 64'd0);

    // R9 then R13: error flag and result hold while inputs move
    runOp(3'd5, 2'd1, 64'h1234, 64'h0001_0000, 64'h5555_6666_7777_8888, r, e, lat);
    check("R9 zero low-half divisor result", r, 64'h5555_6666_7777_8888);
    check("R9 zero divisor flag", 64'(e), 64'd1);
    srcA = 64'd9; srcB = 64'd0; destIn = 64'd0; opSel = 3'd0;
    repeat (5) @(negedge clk);
    check("R13 result held", result, 64'h5555_6666_7777_8888);
    check("R13 divErr held", 64'(divErr), 64'd1);
    runOp(3'd4, 2'd0, 64'd9, 64'd3, DST, r, e, lat);
    check("R9 flag cleared", 64'(e), 64'd0);
    check("R7 small quotient", r, 64'hAAAA_AAAA_AAAA_AA03);
    check("R10 byte divide latency", 64'(lat), 64'd10);

    summary();
    $finish;
  end

endmodule